// File: doc/BRIEF.md
# Polling Responder with Time-Slot Scheduling

This block decides how an emulated contactless tag answers a reader. A deframer upstream hands it a decoded frame: length byte, command byte, the two poll parameter bytes, a CRC verdict and the tick at which the frame ended. The block picks one of three canned replies: a short poll reply, a long poll reply or a fixed read reply. It also works out the tick at which transmission may start. It then passes the reply length, the start tick and a byte-indexed read port to a frame transmitter. The block stays in respond mode until the transmitter reports completion. After that it releases the deframer for the next frame.

Poll replies are placed in reader-defined time slots. An internal slot counter moves forward after every poll that is answered. It falls back to slot 0 whenever it exceeds the highest slot the reader allows. An 8-byte tag identifier is written through a small configuration port. Each write makes a serial engine recompute the three reply CRCs once. Transmission then reads stored CRCs and does no CRC work at send time.

Top module: `slot_poll_responder`

## Requirements
- R1: A CRC-valid frame with length byte 6, command byte 0x00 and request code 0 gets the 22-byte reply B2 4D 12 01, then identifier bytes 0..7 at positions 4..11, then 00 F1 00 00 00 01 43 00 at positions 12..19, then the CRC.
- R2: The same poll with request code 1 gets the 24-byte reply B2 4D 14 01, identifier, the 8 parameter bytes of R1, system code 88 B4 at positions 20..21, then the CRC.
- R3: A poll with a request code other than 0 or 1 gets no reply. The slot counter does not advance, and rx_clear_o pulses the cycle after rx_done_i.
- R4: A poll reply's start tick is eof + 2049 + 1024*slot. The slot counter is 0 after reset and advances by one after each answered poll.
- R5: When the slot counter is greater than the max-slot byte of the poll, slot 0 is used, so the counter becomes 1. A counter equal to the max-slot byte is used as is.
- R6: A CRC-valid frame with length byte greater than 5 and command 0x06 gets the 33-byte reply B2 4D 1D 07, identifier, then 00 00 01 10 04 01 00 0D 00 00 00 00 00 01 00 00 00 00 23 at positions 12..30, then the CRC. Its start tick equals the end-of-frame tick. A length byte of 5 gets no reply.
- R7: A frame with a bad CRC gets no reply. rx_clear_o pulses the cycle after rx_done_i, and listen_o stays high.
- R8: The last two reply bytes are CRC-16 (polynomial 0x1021, initial value 0, MSB-first) over positions 2 through the last body byte, high byte first. The CRCs are recomputed after reset and after each identifier write. listen_o is low while they are computed.
- R9: tx_start_o pulses for one cycle the cycle after an accepted frame, and listen_o falls with it. listen_o returns high, with a one-cycle rx_clear_o pulse, the cycle after tx_done_i.
- R10: Frames matching neither command get no reply and an rx_clear_o pulse the cycle after rx_done_i. Reading tx_byte_o at an index at or beyond tx_len_o gives 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Identifier byte write strobe |
| cfg_addr_i | input | 3 | Identifier byte index (0 goes to reply position 4) |
| cfg_data_i | input | 8 | Identifier byte value |
| rx_done_i | input | 1 | Deframer has a complete frame (one-cycle pulse) |
| rx_crc_ok_i | input | 1 | Frame CRC check passed |
| rx_len_i | input | 8 | Frame length byte (position 2) |
| rx_cmd_i | input | 8 | Command byte (position 3) |
| rx_req_i | input | 8 | Poll request code (position 6) |
| rx_maxslot_i | input | 8 | Poll highest permitted slot (position 7) |
| rx_eof_i | input | TICK_W | Tick at end of frame |
| rx_clear_o | output | 1 | Reset pulse to the deframer |
| listen_o | output | 1 | High in listen mode |
| tx_start_o | output | 1 | Reply ready pulse to the transmitter |
| tx_len_o | output | 6 | Reply length in bytes |
| tx_at_o | output | TICK_W | Tick at which transmission starts |
| tx_idx_i | input | 6 | Reply byte index requested by the transmitter |
| tx_byte_o | output | 8 | Reply byte at tx_idx_i |
| tx_done_i | input | 1 | Transmitter finished the reply |

## Verification
The assertions assume the following about the inputs. rx_done_i comes only while listen_o is high. tx_done_i comes only while a reply is pending. Identifier writes happen only in listen mode, never during a reply. The stimulus meets these by waiting for listen_o before every frame and every write. It raises tx_done_i only after it has seen tx_start_o, and it keeps every strobe to a single cycle driven on the falling edge. Slot behaviour is covered through a planned sequence of max-slot values: wrap, equality and unanswered polls in between. Expected slot ticks and reply bytes, including the CRCs, are built independently in the bench.

// File: rtl/pollrsp_pkg.sv
package pollrsp_pkg;
  typedef enum logic [1:0] {
    RSP_POLL_S = 2'd0,
    RSP_POLL_L = 2'd1,
    RSP_READ   = 2'd2,
    RSP_NONE   = 2'd3
  } rsp_kind_e;

  localparam int unsigned IDX_W = 6;
  localparam logic [7:0] SYNC_HI  = 8'hB2;
  localparam logic [7:0] SYNC_LO  = 8'h4D;
  localparam logic [7:0] CMD_POLL = 8'h00;
  localparam logic [7:0] CMD_READ = 8'h06;
  localparam logic [7:0] ACK_POLL = 8'h01;
  localparam logic [7:0] ACK_READ = 8'h07;
  // byte k of a field sits at [top-8k -: 8]
  localparam logic [63:0]  POLL_PARAM = 64'h00F1_0000_0001_4300;
  localparam logic [151:0] READ_TAIL  =
    152'h0000_0110_0401_000D_0000_0000_0001_0000_0000_23;

  function automatic logic [IDX_W-1:0] rsp_len(rsp_kind_e k);
    case (k)
      RSP_POLL_S: return IDX_W'(22);
      RSP_POLL_L: return IDX_W'(24);
      RSP_READ:   return IDX_W'(33);
      default:    return '0;
    endcase
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction
endpackage

// File: rtl/resp_rom.sv
module resp_rom
  import pollrsp_pkg::*;
#(
  parameter logic [15:0] SYS_CODE = 16'h88B4
) (
  input  rsp_kind_e        kind_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [63:0]      id_i,
  input  logic [15:0]      crc_i,
  output logic [7:0]       byte_o
);
  logic [IDX_W-1:0] len_w;
  logic [IDX_W-1:0] last_w;
  int               k;

  assign len_w  = rsp_len(kind_i);
  assign last_w = len_w - IDX_W'(1);

  always_comb begin
    k      = int'(idx_i);
    byte_o = 8'h00;
    if (idx_i >= len_w)               byte_o = 8'h00;
    else if (idx_i == 0)              byte_o = SYNC_HI;
    else if (idx_i == 1)              byte_o = SYNC_LO;
    else if (idx_i == 2)              byte_o = 8'(len_w) - 8'd4;
    else if (idx_i == 3)              byte_o = (kind_i == RSP_READ) ? ACK_READ : ACK_POLL;
    else if (idx_i == last_w - IDX_W'(1)) byte_o = crc_i[15:8];
    else if (idx_i == last_w)         byte_o = crc_i[7:0];
    else if (k < 12)                  byte_o = id_i[63-8*(k-4) -: 8];
    else if (kind_i == RSP_READ)      byte_o = READ_TAIL[151-8*(k-12) -: 8];
    else if (k < 20)                  byte_o = POLL_PARAM[63-8*(k-12) -: 8];
    else if (k == 20)                 byte_o = SYS_CODE[15:8];
    else                              byte_o = SYS_CODE[7:0];
  end
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import pollrsp_pkg::*;
#(
  parameter logic [15:0] SYS_CODE = 16'h88B4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [63:0] id_i,
  input  rsp_kind_e   rd_kind_i,
  output logic        busy_o,
  output logic [15:0] crc_o
);
  rsp_kind_e        kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      acc_q;
  logic             busy_q;
  logic [15:0]      crc_q [4];
  logic [7:0]       rom_byte;
  logic [15:0]      acc_n;

  resp_rom #(.SYS_CODE(SYS_CODE)) u_rom (
    .kind_i(kind_q), .idx_i(idx_q), .id_i(id_i), .crc_i(16'h0000), .byte_o(rom_byte)
  );

  assign acc_n  = crc_step(acc_q, rom_byte);
  assign busy_o = busy_q;
  assign crc_o  = crc_q[rd_kind_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      kind_q <= RSP_POLL_S;
      idx_q  <= IDX_W'(2);
      acc_q  <= '0;
      for (int i = 0; i < 4; i++) crc_q[i] <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      kind_q <= RSP_POLL_S;
      idx_q  <= IDX_W'(2);
      acc_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == rsp_len(kind_q) - IDX_W'(3)) begin
        crc_q[kind_q] <= acc_n;
        acc_q         <= '0;
        idx_q         <= IDX_W'(2);
        if (kind_q == RSP_READ) busy_q <= 1'b0;
        else                    kind_q <= rsp_kind_e'(kind_q + 2'd1);
      end else begin
        acc_q <= acc_n;
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  a_r8_restart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r8_ends_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(kind_q) == RSP_READ);
endmodule

// File: rtl/slot_sched.sv
module slot_sched #(
  parameter int unsigned SLOT_W      = 5,
  parameter int unsigned TICK_W      = 32,
  parameter int unsigned SLOT0_TICKS = 2048,
  parameter int unsigned SLOT_TICKS  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [7:0]        max_i,
  input  logic [TICK_W-1:0] eof_i,
  output logic [TICK_W-1:0] at_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_use;

  assign slot_use = (8'(slot_q) > max_i) ? '0 : slot_q;
  assign at_o = eof_i + TICK_W'(SLOT0_TICKS) + TICK_W'(slot_use) * TICK_W'(SLOT_TICKS)
              + TICK_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (take_i) slot_q <= slot_use + SLOT_W'(1);
  end

  a_r4_slot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && 8'(slot_q) <= max_i) |=> slot_q == $past(slot_q) + SLOT_W'(1));
  a_r5_slot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && 8'(slot_q) > max_i) |=> slot_q == SLOT_W'(1));
  a_r4_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(slot_q));
endmodule

// File: rtl/slot_poll_responder.sv
module slot_poll_responder
  import pollrsp_pkg::*;
#(
  parameter int unsigned TICK_W      = 32,
  parameter int unsigned SLOT_W      = 5,
  parameter int unsigned SLOT0_TICKS = 2048,
  parameter int unsigned SLOT_TICKS  = 1024,
  parameter logic [15:0] SYS_CODE    = 16'h88B4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [7:0]        cfg_data_i,
  input  logic              rx_done_i,
  input  logic              rx_crc_ok_i,
  input  logic [7:0]        rx_len_i,
  input  logic [7:0]        rx_cmd_i,
  input  logic [7:0]        rx_req_i,
  input  logic [7:0]        rx_maxslot_i,
  input  logic [TICK_W-1:0] rx_eof_i,
  output logic              rx_clear_o,
  output logic              listen_o,
  output logic              tx_start_o,
  output logic [5:0]        tx_len_o,
  output logic [TICK_W-1:0] tx_at_o,
  input  logic [5:0]        tx_idx_i,
  output logic [7:0]        tx_byte_o,
  input  logic              tx_done_i
);
  typedef enum logic [1:0] {ST_CRC, ST_LISTEN, ST_TX} state_e;

  state_e            state_q;
  rsp_kind_e         kind_q;
  rsp_kind_e         pick;
  logic [TICK_W-1:0] at_q;
  logic [TICK_W-1:0] slot_at;
  logic [63:0]       id_q;
  logic [15:0]       crc_w;
  logic              start_q;
  logic              clear_q;
  logic              crc_busy;
  logic              is_poll;
  logic              is_read;
  logic              accept;
  logic              take;

  assign is_poll = (rx_len_i == 8'd6) && (rx_cmd_i == CMD_POLL);
  assign is_read = (rx_len_i > 8'd5) && (rx_cmd_i == CMD_READ);
  assign accept  = (state_q == ST_LISTEN) && rx_done_i && !cfg_we_i;

  always_comb begin
    pick = RSP_NONE;
    if (rx_crc_ok_i) begin
      if (is_poll && rx_req_i == 8'd0)      pick = RSP_POLL_S;
      else if (is_poll && rx_req_i == 8'd1) pick = RSP_POLL_L;
      else if (is_read)                     pick = RSP_READ;
    end
  end

  assign take = accept && (pick == RSP_POLL_S || pick == RSP_POLL_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       id_q <= '0;
    else if (cfg_we_i) id_q[63-8*int'(cfg_addr_i) -: 8] <= cfg_data_i;
  end

  crc_unit #(.SYS_CODE(SYS_CODE)) u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cfg_we_i), .id_i(id_q),
    .rd_kind_i(kind_q), .busy_o(crc_busy), .crc_o(crc_w)
  );

  slot_sched #(
    .SLOT_W(SLOT_W), .TICK_W(TICK_W), .SLOT0_TICKS(SLOT0_TICKS), .SLOT_TICKS(SLOT_TICKS)
  ) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .max_i(rx_maxslot_i),
    .eof_i(rx_eof_i), .at_o(slot_at)
  );

  resp_rom #(.SYS_CODE(SYS_CODE)) u_out (
    .kind_i(kind_q), .idx_i(tx_idx_i), .id_i(id_q), .crc_i(crc_w), .byte_o(tx_byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CRC;
      kind_q  <= RSP_NONE;
      at_q    <= '0;
      start_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      clear_q <= 1'b0;
      case (state_q)
        ST_CRC: if (!crc_busy && !cfg_we_i) state_q <= ST_LISTEN;
        ST_LISTEN: begin
          if (cfg_we_i) state_q <= ST_CRC;
          else if (accept) begin
            if (pick != RSP_NONE) begin
              kind_q  <= pick;
              at_q    <= (pick == RSP_READ) ? rx_eof_i : slot_at;
              start_q <= 1'b1;
              state_q <= ST_TX;
            end else begin
              clear_q <= 1'b1;
            end
          end
        end
        ST_TX: if (tx_done_i) begin
          state_q <= ST_LISTEN;
          clear_q <= 1'b1;
        end
        default: state_q <= ST_CRC;
      endcase
    end
  end

  assign listen_o   = (state_q == ST_LISTEN);
  assign tx_start_o = start_q;
  assign rx_clear_o = clear_q;
  assign tx_len_o   = rsp_len(kind_q);
  assign tx_at_o    = at_q;

  a_r9_start_leaves_listen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !listen_o);
  a_r9_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);
  a_r9_done_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && tx_done_i) |=> (listen_o && rx_clear_o));
  a_r7_bad_crc_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listen_o && rx_done_i && !rx_crc_ok_i && !cfg_we_i) |=> (!tx_start_o && rx_clear_o && listen_o));
  a_r3_unknown_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listen_o && rx_done_i && rx_crc_ok_i && is_poll && rx_req_i > 8'd1 && !cfg_we_i)
      |=> (!tx_start_o && rx_clear_o));
  a_r8_quiet_while_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_busy |-> !tx_start_o);
endmodule

// File: tb/slot_poll_responder_test.sv
`timescale 1ns/1ps
module slot_poll_responder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_data_i = '0;
  logic        rx_done_i = 1'b0;
  logic        rx_crc_ok_i = 1'b0;
  logic [7:0]  rx_len_i = '0, rx_cmd_i = '0, rx_req_i = '0, rx_maxslot_i = '0;
  logic [31:0] rx_eof_i = '0;
  logic        rx_clear_o, listen_o, tx_start_o, tx_done_i = 1'b0;
  logic [5:0]  tx_len_o;
  logic [31:0] tx_at_o;
  logic [5:0]  tx_idx_i = '0;
  logic [7:0]  tx_byte_o;

  int checks = 0;
  int errors = 0;
  bit ended = 0;
  logic [7:0] idb [8];
  logic [7:0] exp_b [40];
  int exp_n;

  always #2 clk_i = ~clk_i;

  slot_poll_responder uut (.*);

  task automatic check(string r, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_of(int first, int last);
    logic [15:0] c = 16'h0;
    for (int i = first; i <= last; i++)
      for (int b = 7; b >= 0; b--) begin
        logic t = c[15] ^ exp_b[i][b];
        c = c << 1;
        if (t) c ^= 16'h1021;
      end
    return c;
  endfunction

  // kind 0 short poll, 1 long poll, 2 read
  task automatic build(int kind);
    logic [7:0] prm [8] = '{8'h00, 8'hF1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h43, 8'h00};
    logic [7:0] tl [19] = '{8'h00, 8'h00, 8'h01, 8'h10, 8'h04, 8'h01, 8'h00, 8'h0D,
                            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00,
                            8'h00, 8'h00, 8'h23};
    logic [15:0] c;
    exp_n = (kind == 0) ? 22 : (kind == 1) ? 24 : 33;
    exp_b[0] = 8'hB2; exp_b[1] = 8'h4D; exp_b[2] = 8'(exp_n - 4);
    exp_b[3] = (kind == 2) ? 8'h07 : 8'h01;
    for (int i = 0; i < 8; i++) exp_b[4+i] = idb[i];
    if (kind == 2) for (int i = 0; i < 19; i++) exp_b[12+i] = tl[i];
    else for (int i = 0; i < 8; i++) exp_b[12+i] = prm[i];
    if (kind == 1) begin exp_b[20] = 8'h88; exp_b[21] = 8'hB4; end
    c = crc_of(2, exp_n - 3);
    exp_b[exp_n-2] = c[15:8];
    exp_b[exp_n-1] = c[7:0];
  endtask

  task automatic check_bytes(string r);
    int bad = 0;
    logic [7:0] a = 0, e = 0;
    for (int i = 0; i < exp_n; i++) begin
      tx_idx_i = 6'(i);
      #0.2;
      if (tx_byte_o !== exp_b[i] && bad == 0) begin a = tx_byte_o; e = exp_b[i]; end
      if (tx_byte_o !== exp_b[i]) bad++;
    end
    check({r, " reply bytes"}, a, e);
    tx_idx_i = 6'(exp_n);
    #0.2;
    check("R10 byte past length", tx_byte_o, 0);
  endtask

  task automatic wait_listen(string r);
    int n = 0;
    while (!listen_o && n < 500) begin @(negedge clk_i); n++; end
    check({r, " listen reached"}, listen_o, 1);
  endtask

  task automatic send(bit ok, logic [7:0] len, cmd, req, mx, logic [31:0] eof);
    @(negedge clk_i);
    rx_crc_ok_i = ok; rx_len_i = len; rx_cmd_i = cmd; rx_req_i = req;
    rx_maxslot_i = mx; rx_eof_i = eof; rx_done_i = 1'b1;
    @(negedge clk_i);
    rx_done_i = 1'b0;
  endtask

  task automatic finish_tx(string r);
    @(negedge clk_i); tx_done_i = 1'b1;
    @(negedge clk_i); tx_done_i = 1'b0;
    check({r, " listen after done"}, listen_o, 1);
    check({r, " clear after done"}, rx_clear_o, 1);
    @(negedge clk_i);
    check({r, " clear is a pulse"}, rx_clear_o, 0);
  endtask

  task automatic load_id(logic [7:0] base);
    for (int i = 0; i < 8; i++) begin
      idb[i] = base + 8'(i * 17);
      @(negedge clk_i);
      cfg_we_i = 1'b1; cfg_addr_i = 3'(i); cfg_data_i = idb[i];
    end
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    check("R8 listen low while computing", listen_o, 0);
    wait_listen("R8");
  endtask

  task automatic poll_case(string r, logic [7:0] req, mx, logic [31:0] eof, int slot);
    send(1, 8'd6, 8'h00, req, mx, eof);
    check({r, " start pulse"}, tx_start_o, 1);
    check("R9 listen low with start", listen_o, 0);
    check({r, " slot tick"}, tx_at_o, eof + 2049 + 1024 * slot);
    build(int'(req));
    check({r, " length"}, tx_len_o, exp_n);
    check_bytes(r);
    @(negedge clk_i);
    check("R9 start single cycle", tx_start_o, 0);
    finish_tx(r);
  endtask

  task automatic silent_case(string r, bit ok, logic [7:0] len, cmd, req);
    send(ok, len, cmd, req, 8'd15, 32'd7000);
    check({r, " no reply"}, tx_start_o, 0);
    check({r, " clear pulse"}, rx_clear_o, 1);
    check({r, " stays listening"}, listen_o, 1);
  endtask

  task automatic read_case(string r, logic [7:0] len, logic [31:0] eof);
    send(1, len, 8'h06, 8'h00, 8'h00, eof);
    check({r, " start pulse"}, tx_start_o, 1);
    check({r, " start tick"}, tx_at_o, eof);
    build(2);
    check({r, " length"}, tx_len_o, 33);
    check_bytes(r);
    finish_tx(r);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset no start", tx_start_o, 0);
    check("R10 reset no clear", rx_clear_o, 0);
    check("R8 reset computing", listen_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) idb[i] = 8'h00;
    wait_listen("R8 after reset");
    poll_case("R1 zero id", 8'd0, 8'd3, 32'd500, 0);
    load_id(8'h21);
    poll_case("R1", 8'd0, 8'd3, 32'd1000, 1);
    poll_case("R2", 8'd1, 8'd3, 32'd3000, 2);
    poll_case("R5 wrap", 8'd0, 8'd0, 32'd5000, 0);
    poll_case("R4 next slot", 8'd0, 8'd15, 32'd9000, 1);
    silent_case("R3 request 5", 1, 8'd6, 8'h00, 8'd5);
    poll_case("R3 counter held", 8'd1, 8'd15, 32'd12000, 2);
    poll_case("R5 equal kept", 8'd0, 8'd3, 32'd20000, 3);
    silent_case("R7 bad crc", 0, 8'd6, 8'h00, 8'd0);
    silent_case("R6 read len 5", 1, 8'd5, 8'h06, 8'd0);
    silent_case("R10 len 7 poll cmd", 1, 8'd7, 8'h00, 8'd0);
    silent_case("R10 other cmd", 1, 8'd16, 8'h04, 8'd0);
    read_case("R6", 8'd16, 32'd40000);
    read_case("R6 min len", 8'd6, 32'd41000);
    load_id(8'hC3);
    poll_case("R8 new id", 8'd1, 8'd15, 32'd50000, 4);
    read_case("R8 new id read", 8'd16, 32'd60000);
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule